// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one memory burst. A burst is requested with a one-cycle start pulse. The pulse carries a start column, a burst length code, an ordering bit and a few qualifiers. From the next cycle on, the block issues one column per cycle. It flags the final beat of a fixed-length burst and pulses a completion strobe once the burst has ended.

Two orderings are supported. In linear ordering, the low column bits count up and wrap inside the aligned block. In XOR ordering, the low column bits are the start value XOR the beat number. A page-length burst walks the whole column space, wrapping from the top column to column zero, and runs until it is stopped.

Three further features shape the behaviour:
- A stop input ends any burst at once.
- A single-write mode shortens writes to one beat while reads keep the programmed length.
- Illegal mode combinations are refused and reported, and no beat is issued for them.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first legal start, valid_o, last_o, done_o and illegal_o are all low.
- R2: A legal start sampled at a clock edge makes valid_o high from that edge for exactly N consecutive cycles, one column per cycle. N is set by len_i: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a page burst (256 columns at COL_W=8).
- R3: With order_i=0, beat k carries the start column's upper bits unchanged. Its low log2(N) bits are (start + k) mod N.
- R4: With order_i=1, beat k carries the start column's upper bits unchanged. Its low log2(N) bits are start XOR k.
- R5: A page burst (len_i=7, order_i=0) issues start + k modulo 2^COL_W on beat k. It wraps past the top column, never raises last_o, and continues until stopped.
- R6: last_o is high on the final beat of a fixed-length burst, and only on that beat.
- R7: stop_i sampled high during a burst makes valid_o low from the next cycle. stop_i sampled while idle has no effect: done_o and valid_o stay low.
- R8: With single_wr_i=1 and write_i=1, a burst is one beat long and last_o is high on that beat. With single_wr_i=1 and write_i=0, the programmed length applies.
- R9: len_i values 4, 5 or 6, or len_i=7 with order_i=1, are illegal. An illegal start issues no beat and raises illegal_o for exactly the one cycle after the start.
- R10: len_i=7 with auto_pre_i=1 is illegal, unless single_wr_i=1 and write_i=1. In that case a single beat is issued.
- R11: done_o is high for exactly one cycle: the cycle after the final beat, or the cycle after stop_i was sampled during a burst.
- R12: A start sampled during a burst abandons the old burst. A legal start then begins a new burst from beat 0; an illegal one leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request, one cycle |
| start_col_i | input | COL_W | First column of the burst |
| len_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 linear, 1 XOR ordering |
| single_wr_i | input | 1 | Single-write mode enable |
| write_i | input | 1 | Request is a write |
| auto_pre_i | input | 1 | Request carries auto precharge |
| stop_i | input | 1 | Terminate current burst |
| col_o | output | COL_W | Current column, zero when idle |
| valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Final beat of a fixed burst |
| done_o | output | 1 | Burst ended, one-cycle pulse |
| illegal_o | output | 1 | Previous start was refused |

## Verification
Timing is counted from the rising edge at which start_i is sampled:
- Beat k appears k+1 cycles after that edge.
- done_o appears one cycle after the final beat, or one cycle after the edge at which stop_i is sampled.
- illegal_o appears one cycle after a refused start.

Inputs are driven on falling edges, so every sample point falls midway between edges. A driver task computes the expected column and last-beat flag for every beat from the requirement formulas and queues them. A monitor pops and compares one entry on each falling edge where valid_o is high. The driver checks done_o, illegal_o and an empty queue at the exact falling edge where each is due.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_W = 3;
  localparam logic [LEN_W-1:0] LEN_MAX_FIXED = 3'd3;
  localparam logic [LEN_W-1:0] LEN_PAGE      = 3'd7;

  typedef struct packed {
    logic page;
    logic xor_ord;
    logic bad;
  } mode_flags_t;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             order_i,
  input  logic             single_wr_i,
  input  logic             write_i,
  input  logic             auto_pre_i,
  output logic [COL_W-1:0] mask_o,
  output mode_flags_t      flags_o
);
  logic one_beat_wr;
  logic reserved;
  logic page_code;

  assign one_beat_wr = single_wr_i && write_i;
  assign page_code   = (len_i == LEN_PAGE);
  assign reserved    = (len_i > LEN_MAX_FIXED) && !page_code;

  always_comb begin
    flags_o.bad     = reserved || (page_code && order_i) ||
                      (page_code && auto_pre_i && !one_beat_wr);
    flags_o.page    = page_code && !one_beat_wr;
    flags_o.xor_ord = order_i;
    if (one_beat_wr) begin
      mask_o = '0;
    end else if (page_code) begin
      mask_o = '1;
    end else begin
      mask_o = COL_W'((1 << len_i[1:0]) - 1);
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             abort_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             last_o,
  output logic             done_o
);
  logic             active_q;
  logic             page_q;
  logic             done_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;

  assign last_o   = active_q && !page_q && (beat_q == mask_q);
  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      page_q   <= 1'b0;
      done_q   <= 1'b0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        mask_q   <= mask_i;
        page_q   <= page_i;
      end else if (abort_i) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (stop_i || last_o) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;  // page bursts wrap naturally
        end
      end
    end
  end

  assert_stop_halts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && stop_i && !load_i && !abort_i |=> !active_q && done_q);

  assert_last_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !load_i && !abort_i |=> !active_q && done_q);

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !active_q);

  assert_page_runs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && page_q && !stop_i && !load_i && !abort_i |=> active_q);

  assert_restart_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_q && (beat_q == '0));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             xor_ord_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low_lin;
  logic [COL_W-1:0] low_xor;

  assign low_lin = base_i + beat_i;
  assign low_xor = base_i ^ beat_i;

  // upper bits hold, low bits move inside the aligned block
  assign col_o = (base_i & ~mask_i) | ((xor_ord_i ? low_xor : low_lin) & mask_i);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             order_i,
  input  logic             single_wr_i,
  input  logic             write_i,
  input  logic             auto_pre_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             done_o,
  output logic             illegal_o
);
  logic [COL_W-1:0] dec_mask;
  mode_flags_t      dec_flags;
  logic             load;
  logic             abort;
  logic [COL_W-1:0] base_q;
  logic             xor_q;
  logic             illegal_q;
  logic             active;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] col_raw;

  burst_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_i       (len_i),
    .order_i     (order_i),
    .single_wr_i (single_wr_i),
    .write_i     (write_i),
    .auto_pre_i  (auto_pre_i),
    .mask_o      (dec_mask),
    .flags_o     (dec_flags)
  );

  assign load  = start_i && !dec_flags.bad;
  assign abort = start_i && dec_flags.bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      xor_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= abort;
      if (load) begin
        base_q <= start_col_i;
        xor_q  <= dec_flags.xor_ord;
      end
    end
  end

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .abort_i  (abort),
    .mask_i   (dec_mask),
    .page_i   (dec_flags.page),
    .stop_i   (stop_i),
    .active_o (active),
    .beat_o   (beat),
    .mask_o   (mask_q),
    .last_o   (last_o),
    .done_o   (done_o)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i    (base_q),
    .beat_i    (beat),
    .mask_i    (mask_q),
    .xor_ord_i (xor_q),
    .col_o     (col_raw)
  );

  assign col_o     = active ? col_raw : '0;
  assign valid_o   = active;
  assign illegal_o = illegal_q;

  assert_refuse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && dec_flags.bad |=> illegal_o && !valid_o);

  assert_lin_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !stop_i && !start_i && !xor_q
    |=> ((col_o - $past(col_o)) & mask_q) == COL_W'(1));

  assert_single_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && single_wr_i && write_i && !dec_flags.bad |=> valid_o && last_o);

  assert_idle_col_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (col_o == '0) && !last_o);
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_i = '0;
  logic             order_i = 1'b0;
  logic             single_wr_i = 1'b0;
  logic             write_i = 1'b0;
  logic             auto_pre_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, done_o, illegal_o;

  typedef struct {
    logic [COL_W-1:0] col;
    logic             last;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_i(len_i), .order_i(order_i), .single_wr_i(single_wr_i), .write_i(write_i),
    .auto_pre_i(auto_pre_i), .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o),
    .last_o(last_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: one queued entry per valid beat
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected beat col", int'(col_o), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(col_o == e.col, e.req, "beat column", int'(col_o), int'(e.col));
        chk(last_o == e.last, "R6", "last flag", int'(last_o), int'(e.last));
      end
    end
  end

  task automatic burst(input logic [7:0] sc, input logic [2:0] bl, input bit xo,
                       input bit sw, input bit wr, input bit ap, input int stop_at,
                       input string req);
    bit page;
    int len, cnt, mask;
    page = (bl == 3'd7);
    if (sw && wr) len = 1;
    else if (page) len = 256;
    else len = 1 << bl;
    cnt  = (stop_at > 0 && stop_at < len) ? stop_at : len;
    mask = (page && len > 1) ? 255 : len - 1;
    for (int k = 0; k < cnt; k++) begin
      exp_t e;
      if (page && len > 1) e.col = 8'((sc + k) & 255);
      else if (xo) e.col = 8'((sc & ~mask) | ((sc ^ k) & mask));
      else e.col = 8'((sc & ~mask) | ((sc + k) & mask));
      e.last = !(page && len > 1) && (k == len - 1);
      e.req  = req;
      exp_q.push_back(e);
    end
    start_col_i = sc; len_i = bl; order_i = xo;
    single_wr_i = sw; write_i = wr; auto_pre_i = ap;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (stop_at > 0) begin
      repeat (cnt - 1) @(negedge clk);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
    end else begin
      repeat (cnt) @(negedge clk);
    end
    chk(done_o == 1'b1, "R11", {req, " done after burst"}, int'(done_o), 1);
    chk(valid_o == 1'b0, (stop_at > 0) ? "R7" : "R2", {req, " valid after end"},
        int'(valid_o), 0);
    chk(exp_q.size() == 0, "R2", {req, " beats left"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk(done_o == 1'b0, "R11", "done pulse width", int'(done_o), 0);
  endtask

  task automatic refused(input logic [2:0] bl, input bit xo, input bit ap,
                         input string req);
    start_col_i = 8'h10; len_i = bl; order_i = xo;
    single_wr_i = 1'b0; write_i = 1'b0; auto_pre_i = ap;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(illegal_o == 1'b1, req, "illegal flag", int'(illegal_o), 1);
    chk(valid_o == 1'b0, req, "no beat on refusal", int'(valid_o), 0);
    @(negedge clk);
    chk(illegal_o == 1'b0, req, "illegal pulse width", int'(illegal_o), 0);
    chk(valid_o == 1'b0 && done_o == 1'b0, req, "idle after refusal",
        int'({valid_o, done_o}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({valid_o, last_o, done_o, illegal_o} == 4'b0, "R1", "reset outputs",
        int'({valid_o, last_o, done_o, illegal_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({valid_o, last_o, done_o, illegal_o} == 4'b0, "R1", "idle after reset",
        int'({valid_o, last_o, done_o, illegal_o}), 0);

    burst(8'h2E, 3'd2, 1'b0, 0, 0, 0, 0, "R3");   // 2E 2F 2C 2D
    burst(8'h35, 3'd3, 1'b1, 0, 0, 0, 0, "R4");   // 35^k
    burst(8'h7F, 3'd1, 1'b0, 0, 0, 0, 0, "R3");   // 7F 7E
    burst(8'h7F, 3'd1, 1'b1, 0, 0, 0, 0, "R4");
    burst(8'hA3, 3'd0, 1'b0, 0, 0, 0, 0, "R2");
    burst(8'h5A, 3'd3, 1'b0, 0, 0, 0, 0, "R3");
    burst(8'hFE, 3'd7, 1'b0, 0, 0, 0, 5, "R5");   // FE FF 00 01 02
    burst(8'h00, 3'd7, 1'b0, 0, 0, 0, 40, "R5");
    burst(8'h41, 3'd3, 1'b1, 0, 0, 0, 3, "R7");
    burst(8'h64, 3'd3, 1'b0, 1, 1, 0, 0, "R8");   // one beat
    burst(8'h64, 3'd3, 1'b0, 1, 0, 0, 0, "R8");   // read keeps 8
    burst(8'h22, 3'd7, 1'b0, 1, 1, 1, 0, "R10");  // legal single beat

    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0 && valid_o == 1'b0, "R7", "idle stop ignored",
        int'({done_o, valid_o}), 0);

    refused(3'd5, 1'b0, 1'b0, "R9");
    refused(3'd7, 1'b1, 1'b0, "R9");
    refused(3'd7, 1'b0, 1'b1, "R10");

    // R12: restart mid burst, then abort by an illegal start
    begin
      exp_t e;
      e.req = "R12";
      for (int k = 0; k < 2; k++) begin
        e.col = 8'(8'h10 + k); e.last = 1'b0; exp_q.push_back(e);
      end
      for (int k = 0; k < 4; k++) begin
        e.col = 8'(8'h80 + k); e.last = (k == 3); exp_q.push_back(e);
      end
    end
    start_col_i = 8'h10; len_i = 3'd3; order_i = 1'b0;
    single_wr_i = 1'b0; write_i = 1'b0; auto_pre_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_col_i = 8'h80; len_i = 3'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R12", "no done on restart", int'(done_o), 0);
    @(negedge clk);
    len_i = 3'd4; start_i = 1'b1;   // illegal start mid burst
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o == 1'b0 && illegal_o == 1'b1, "R12", "abort on illegal start",
        int'({valid_o, illegal_o}), 1);
    chk(exp_q.size() == 2, "R12", "beats before abort", exp_q.size(), 2);
    exp_q.delete();
    @(negedge clk);
    chk(done_o == 1'b0 && valid_o == 1'b0, "R12", "idle after abort",
        int'({done_o, valid_o}), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule